// File: doc/BRIEF.md
# Wide Accumulator Arithmetic Unit

This block is the add/shift/round stage of a multiply-accumulate datapath. It holds a small bank of 52-bit two's-complement accumulators. Each accumulator is split into a 4-bit guard extension, a 24-bit upper half and a 24-bit lower half. On every valid cycle one operation reads the selected accumulator, combines it with the 48-bit product input where the operation uses the product, and writes the result back into the same accumulator at the next clock edge. The unit has no pipeline, so operations can follow each other on consecutive cycles and each one sees the result of the one before it.

The product is always sign-extended to 52 bits. The add and subtract codes can pre-shift the product 24 bits to the right, keeping its sign, so that the partial products of a double-precision multiply can be summed at the right weight. Rounding adds one half of the lower half's weight and then clears the lower half. The shift operations move the whole accumulator by one bit and keep its sign.

Each accumulator has an overflow flag. The flag is high whenever the value no longer fits in 48 signed bits. One sticky flag records every overflowing write until a clear input is asserted.

The operation sequencing is a single decode of the code held in the `acc_op_e` enumeration. Its values are NOP, ACC, NACC, ADD, SUB, SHL, SHR and RND. There is no multi-cycle state: each decoded code is one transition of the selected accumulator from its old value to its new value.

Top module: `acc_arith_unit`

## Requirements
- R1: While rst_n is low, and after reset is released until the first write, every accumulator reads zero, every ovf bit is 0 and sticky_ovf is 0.
- R2: With op = 1 (ACC), the selected accumulator becomes its old value plus the product sign-extended from 48 to 52 bits, modulo 2^52. Accumulators that are not selected keep their values.
- R3: With op = 2 (NACC), the selected accumulator becomes its old value minus the sign-extended product. For op 1 and op 2 the align input has no effect.
- R4: With op = 3 (ADD) or op = 4 (SUB) and align = 0, the result equals op 1 or op 2 respectively. With align = 1, the sign-extended product is first shifted arithmetically right by 24 bits.
- R5: op = 5 (SHL) shifts the selected accumulator left by one bit and fills bit 0 with zero. op = 6 (SHR) shifts it right by one bit and copies bit 51 into the vacated top bit.
- R6: op = 7 (RND) adds 0x800000 to the selected accumulator and then forces bits 23:0 of the result to zero.
- R7: When valid is low, or when op = 0 (NOP), no accumulator and no flag changes, whatever the other inputs are.
- R8: ovf[i] is high exactly when bits 51:48 of accumulator i are not all equal to bit 47 of accumulator i, evaluated on the stored value.
- R9: sticky_ovf goes high after any write whose result overflows in the R8 sense. It then stays high until a cycle with clr_sticky high and no overflowing write. If both happen in the same cycle, the set wins.
- R10: An operation presented with valid high is visible on acc_flat and the flags right after the next rising clock edge, and an operation on the following cycle uses that updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Perform the operation on this cycle |
| op | input | 3 | Operation code (0 NOP, 1 ACC, 2 NACC, 3 ADD, 4 SUB, 5 SHL, 6 SHR, 7 RND) |
| acc_sel | input | 1 | Index of the accumulator that is read and written |
| align | input | 1 | Shift the product right by 24 bits for ADD/SUB |
| prod | input | 48 | Signed product operand |
| clr_sticky | input | 1 | Clear the sticky overflow flag |
| acc_flat | output | 104 | Accumulator i occupies bits 52*i+51 : 52*i |
| ovf | output | 2 | Per-accumulator overflow flag |
| sticky_ovf | output | 1 | Sticky overflow flag |

## Verification
Every result is due one clock edge after the inputs that request it: the accumulator, its ovf bit and the sticky flag all change at that edge, and no output depends on the inputs through logic alone. The bench applies each operation on a falling edge and compares all outputs on the following falling edge against its arithmetic model. It then applies the next operation at once, so back-to-back dependence is exercised on every cycle. Idle cycles are checked the same way, one falling edge later, to confirm that nothing has moved.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACC  = 3'd1,
        OP_NACC = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_RND  = 3'd7
    } acc_op_e;

endpackage

// File: rtl/acc_operand_prep.sv
module acc_operand_prep #(
    parameter int PROD_W   = 48,
    parameter int ACC_W    = 52,
    parameter int ALIGN_SH = 24
) (
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0]  p_plain,
    output logic [ACC_W-1:0]  p_aligned
);
    localparam int PAD_W = ACC_W - PROD_W;

    logic signed [ACC_W-1:0] p_ext;

    assign p_ext     = {{PAD_W{prod[PROD_W-1]}}, prod};
    assign p_plain   = p_ext;
    assign p_aligned = p_ext >>> ALIGN_SH;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_arith_pkg::*;
#(
    parameter int ACC_W  = 52,
    parameter int HALF_W = 24,
    parameter int EXT_W  = 4
) (
    input  acc_op_e          op,
    input  logic             align,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] p_plain,
    input  logic [ACC_W-1:0] p_aligned,
    output logic [ACC_W-1:0] res,
    output logic             res_ovf
);
    localparam int NORM_W = 2 * HALF_W;
    localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << (HALF_W - 1);

    logic [ACC_W-1:0] p_sel;
    logic [ACC_W-1:0] rsum;
    logic [EXT_W:0]   top_bits;

    assign p_sel = align ? p_aligned : p_plain;
    assign rsum  = acc_in + RND_K;

    always_comb begin
        unique case (op)
            OP_NOP:  res = acc_in;
            OP_ACC:  res = acc_in + p_plain;
            OP_NACC: res = acc_in - p_plain;
            OP_ADD:  res = acc_in + p_sel;
            OP_SUB:  res = acc_in - p_sel;
            OP_SHL:  res = acc_in << 1;
            OP_SHR:  res = $signed(acc_in) >>> 1;
            OP_RND:  res = {rsum[ACC_W-1:HALF_W], {HALF_W{1'b0}}};
            default: res = acc_in;
        endcase
    end

    assign top_bits = res[ACC_W-1:NORM_W-1];
    assign res_ovf  = (top_bits != {(EXT_W+1){1'b0}}) &&
                      (top_bits != {(EXT_W+1){1'b1}});
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
    parameter int NUM_ACC = 2,
    parameter int ACC_W   = 52,
    parameter int EXT_W   = 4,
    parameter int SEL_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [ACC_W-1:0]         wr_data,
    input  logic                     wr_ovf,
    input  logic                     clr_sticky,
    output logic [ACC_W-1:0]         rd_data,
    output logic [NUM_ACC*ACC_W-1:0] acc_flat,
    output logic [NUM_ACC-1:0]       ovf,
    output logic                     sticky
);
    localparam int NORM_W = ACC_W - EXT_W;

    logic [ACC_W-1:0] acc_q [NUM_ACC];

    assign rd_data = acc_q[wr_sel];

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                acc_q[i] <= wr_data;
            end
        end

        assign acc_flat[i*ACC_W +: ACC_W] = acc_q[i];
        assign ovf[i] = (acc_q[i][ACC_W-1:NORM_W] != {EXT_W{acc_q[i][NORM_W-1]}});

        // R2: a write leaves the other accumulators alone
        a_r2_other_acc_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_sel != SEL_W'(i))) |=> $stable(acc_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (wr_en && wr_ovf) begin
            sticky <= 1'b1;
        end else if (clr_sticky) begin
            sticky <= 1'b0;
        end
    end

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ovf) |=> sticky);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr_sticky) |=> sticky);
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
    import acc_arith_pkg::*;
#(
    parameter int NUM_ACC = 2,
    parameter int EXT_W   = 4,
    parameter int HALF_W  = 24,
    localparam int ACC_W  = EXT_W + 2 * HALF_W,
    localparam int PROD_W = 2 * HALF_W,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic [2:0]               op,
    input  logic [SEL_W-1:0]         acc_sel,
    input  logic                     align,
    input  logic [PROD_W-1:0]        prod,
    input  logic                     clr_sticky,
    output logic [NUM_ACC*ACC_W-1:0] acc_flat,
    output logic [NUM_ACC-1:0]       ovf,
    output logic                     sticky_ovf
);
    acc_op_e          op_e;
    logic [ACC_W-1:0] p_plain;
    logic [ACC_W-1:0] p_aligned;
    logic [ACC_W-1:0] acc_cur;
    logic [ACC_W-1:0] res;
    logic             res_ovf;
    logic             wr_en;

    assign op_e  = acc_op_e'(op);
    assign wr_en = valid && (op_e != OP_NOP);

    acc_operand_prep #(
        .PROD_W  (PROD_W),
        .ACC_W   (ACC_W),
        .ALIGN_SH(HALF_W)
    ) u_prep (
        .prod     (prod),
        .p_plain  (p_plain),
        .p_aligned(p_aligned)
    );

    acc_alu #(
        .ACC_W (ACC_W),
        .HALF_W(HALF_W),
        .EXT_W (EXT_W)
    ) u_alu (
        .op       (op_e),
        .align    (align),
        .acc_in   (acc_cur),
        .p_plain  (p_plain),
        .p_aligned(p_aligned),
        .res      (res),
        .res_ovf  (res_ovf)
    );

    acc_bank #(
        .NUM_ACC(NUM_ACC),
        .ACC_W  (ACC_W),
        .EXT_W  (EXT_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (acc_sel),
        .wr_data   (res),
        .wr_ovf    (res_ovf),
        .clr_sticky(clr_sticky),
        .rd_data   (acc_cur),
        .acc_flat  (acc_flat),
        .ovf       (ovf),
        .sticky    (sticky_ovf)
    );

    // R7: an idle cycle changes no accumulator
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(acc_flat));

    // R6: after a round the low half of the target is zero
    a_r6_round_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op_e == OP_RND)) |=>
        (acc_flat[$past(acc_sel)*ACC_W +: HALF_W] == '0));
endmodule

// File: tb/acc_arith_unit_test.sv
`timescale 1ns/100ps
module acc_arith_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [2:0]   op = 3'd0;
    logic         acc_sel = 1'b0;
    logic         align = 1'b0;
    logic [47:0]  prod = '0;
    logic         clr_sticky = 1'b0;
    logic [103:0] acc_flat;
    logic [1:0]   ovf;
    logic         sticky_ovf;

    int checks = 0;
    int errors = 0;

    logic [51:0] m_acc [2];
    logic        m_sticky;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    acc_arith_unit uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .acc_sel(acc_sel),
        .align(align), .prod(prod), .clr_sticky(clr_sticky),
        .acc_flat(acc_flat), .ovf(ovf), .sticky_ovf(sticky_ovf)
    );

    always #2.5 clk = ~clk;

    function automatic logic [51:0] model_res(input logic [2:0] o, input logic [51:0] a,
                                              input logic [47:0] p, input logic al);
        logic signed [51:0] pe;
        logic signed [51:0] pa;
        logic [51:0] t;
        pe = {{4{p[47]}}, p};
        pa = pe >>> 24;
        case (o)
            3'd1: return a + pe;
            3'd2: return a - pe;
            3'd3: return a + (al ? pa : pe);
            3'd4: return a - (al ? pa : pe);
            3'd5: return {a[50:0], 1'b0};
            3'd6: return {a[51], a[51:1]};
            3'd7: begin
                t = a + 52'h800000;
                return {t[51:24], 24'h0};
            end
            default: return a;
        endcase
    endfunction

    function automatic logic is_ovf(input logic [51:0] v);
        return v[51:48] != {4{v[47]}};
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            3'd7: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [51:0] act, input logic [51:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, "/R10 acc0"}, acc_flat[51:0], m_acc[0]);
        chk({tag, "/R10 acc1"}, acc_flat[103:52], m_acc[1]);
        chk("R8 ovf0", {51'b0, ovf[0]}, {51'b0, is_ovf(m_acc[0])});
        chk("R8 ovf1", {51'b0, ovf[1]}, {51'b0, is_ovf(m_acc[1])});
        chk("R9 sticky", {51'b0, sticky_ovf}, {51'b0, m_sticky});
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic run_op(input logic v, input logic [2:0] o, input logic s,
                          input logic al, input logic [47:0] p, input logic clr);
        logic [51:0] r;
        valid = v; op = o; acc_sel = s; align = al; prod = p; clr_sticky = clr;
        @(posedge clk);
        r = model_res(o, m_acc[s], p, al);
        if (v && o != 3'd0) begin
            if (is_ovf(r)) m_sticky = 1'b1;
            else if (clr) m_sticky = 1'b0;
            m_acc[s] = r;
        end else if (clr) begin
            m_sticky = 1'b0;
        end
        @(negedge clk);
        valid = 1'b0; clr_sticky = 1'b0;
        check_all(v ? op_tag(o) : "R7");
    endtask

    function automatic logic [47:0] pick_val(input int k);
        case (k)
            0: return 48'h0;
            1: return 48'h1;
            2: return 48'hFFFFFFFFFFFF;
            3: return 48'h7FFFFFFFFFFF;
            4: return 48'h800000000000;
            5: return 48'h000000800000;
            6: return 48'h123456ABCDEF;
            default: return 48'hFFFFFF000000;
        endcase
    endfunction

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_acc[0] = '0; m_acc[1] = '0; m_sticky = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2/R3/R4 directed: alignment on ADD versus ACC
        run_op(1'b1, 3'd1, 1'b0, 1'b1, 48'h123456789ABC, 1'b0);
        run_op(1'b1, 3'd3, 1'b0, 1'b1, 48'hFEDCBA987654, 1'b0);
        run_op(1'b1, 3'd4, 1'b1, 1'b1, 48'h000001000000, 1'b0);
        chk("R4 aligned sub", acc_flat[103:52], 52'hFFFFFFFFFFFFF);
        run_op(1'b1, 3'd2, 1'b1, 1'b1, 48'hFFFFFFFFFFFF, 1'b0);
        chk("R3 align ignored", acc_flat[103:52], 52'h0);

        // R6 round: 0x...7FFFFF stays, 0x...800000 carries up
        run_op(1'b1, 3'd1, 1'b1, 1'b0, 48'h0000017FFFFF, 1'b0);
        run_op(1'b1, 3'd7, 1'b1, 1'b0, 48'h0, 1'b0);
        chk("R6 round down", acc_flat[103:52], 52'h0000001000000);
        run_op(1'b1, 3'd1, 1'b1, 1'b0, 48'h000000800000, 1'b0);
        run_op(1'b1, 3'd7, 1'b1, 1'b0, 48'h0, 1'b0);
        chk("R6 round up", acc_flat[103:52], 52'h0000002000000);

        // R5/R8/R9: push into overflow, then clear with set-wins
        run_op(1'b1, 3'd1, 1'b0, 1'b0, 48'h7FFFFFFFFFFF, 1'b0);
        run_op(1'b1, 3'd5, 1'b0, 1'b0, 48'h0, 1'b1);
        chk("R9 set wins over clear", {51'b0, sticky_ovf}, 52'h1);
        run_op(1'b0, 3'd1, 1'b0, 1'b0, 48'h7FFFFFFFFFFF, 1'b0);
        run_op(1'b1, 3'd0, 1'b1, 1'b0, 48'h7FFFFFFFFFFF, 1'b1);
        chk("R9 cleared", {51'b0, sticky_ovf}, 52'h0);
        run_op(1'b1, 3'd6, 1'b0, 1'b0, 48'h0, 1'b0);

        // Near-exhaustive sweep over op, target, align and edge products
        for (int o = 0; o < 8; o++)
            for (int al = 0; al < 2; al++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 8; k++)
                        run_op(1'b1, 3'(o), 1'(s), 1'(al), pick_val(k), 1'((o + k) == 9));

        // Pseudo-random stream including idle cycles and clears
        for (int n = 0; n < 1500; n++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            run_op(rng[63:60] != 4'h0, rng[2:0], rng[3], rng[4],
                   rng[5] ? rng[55:8] : pick_val(int'(rng[58:56])), rng[59] & rng[6]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule